// File: doc/BRIEF.md
# Dual-Channel Compare Timer

A counter of parameterised width advances on an enable pulse taken from a free-running prescaler. Two compare channels share the count. Each channel checks the count against its own compare value and, on a match, drives its output level as its 2-bit output mode selects. The mode can leave the level alone, toggle it, clear it or set it. The same mode decides whether the channel takes over its pin. The pin is actually driven only when the channel's direction enable is also high.

Four counting shapes are available:
- free-running up count;
- up count that clears after it reaches a programmable TOP value;
- single-slope PWM that wraps at TOP;
- dual-slope PWM that turns around at TOP and again at zero.

In the two PWM shapes, software writes a compare value into a buffer. The buffer is copied into the live compare register only on the tick at TOP, so a new duty cycle never tears a period. Two single-cycle pulses mark the wrap point and TOP.

Software programs the block through a small write port with four addresses:
- 0: control
- 1: compare A
- 2: compare B
- 3: TOP

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, both output levels, both override and drive outputs and both flags are 0. Both output modes are 00 and the counting shape is free-running.
- R2: The prescale select `clk_sel` sets when the count advances. Value 0 stops it. Value 1 ticks every cycle. Value 2 ticks when the low 3 bits of a 6-bit free-running cycle counter (reset to 0) are all ones. Value 3 ticks when all 6 bits are ones. Without a tick the count does not change.
- R3: Control bits [1:0] select the counting shape, with 0 meaning free-running. In shape 0 each tick adds one and wraps from all-ones to 0. `ovf_flag` pulses for one cycle after the tick taken at all-ones.
- R4: Shape 1 clears on TOP. The tick taken at TOP loads 0, and any other tick adds one. `cap_flag` pulses after the tick taken at TOP, and `ovf_flag` pulses after the tick taken at all-ones.
- R5: Shape 2 is single-slope PWM. It counts like shape 1, but both `ovf_flag` and `cap_flag` pulse after the tick taken at TOP.
- R6: Shape 3 is dual-slope PWM. Counting up, a tick at or above TOP turns the direction and loads count-1. Counting down, a tick at 0 turns the direction and loads 1. A TOP of 0 holds the count at 0. `cap_flag` pulses after the tick at TOP, and `ovf_flag` pulses after the tick at 0 while counting down.
- R7: Mode 01 toggles the channel's output level on each tick where the count equals the live compare value. Modes are control bits [3:2] for A and [5:4] for B.
- R8: Mode 10 drives the output level to 0 on a match, and mode 11 drives it to 1.
- R9: Mode 00 leaves the output level unchanged, whatever matches occur.
- R10: `oc_override` of a channel is 1 exactly when its mode is not 00. `oc_drive` is 1 exactly when the override is 1 and that channel's `dir_en` bit is 1.
- R11: In shapes 2 and 3, a compare write lands in a buffer. The buffer is copied into the live value only on a tick where the count equals TOP. A write in the same cycle as the copy waits for the next TOP.
- R12: In shapes 0 and 1, a compare write becomes the live value on the next cycle.
- R13: The two channels have independent mode, buffer, live value and output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 compare A, 2 compare B, 3 TOP |
| wr_data | input | WIDTH | Write data |
| clk_sel | input | 2 | Prescale select |
| dir_en | input | 2 | Per-channel pin direction enable (bit 0 = A) |
| oc_level | output | 2 | Compare output levels |
| oc_override | output | 2 | Channel owns its pin |
| oc_drive | output | 2 | Pin driver enabled |
| cnt_o | output | WIDTH | Current count |
| ovf_flag | output | 1 | Wrap/bottom pulse |
| cap_flag | output | 1 | TOP pulse |

## Verification
Every result except `oc_drive` is registered, so it is due in the cycle after the clock edge on which the bench presented the write, tick or match that causes it. `oc_drive` also follows `dir_en` within the same cycle. The bench drives inputs at the falling edge. A bench model advances once per rising edge from the same inputs, and the bench compares every output a quarter period after that rising edge. Every compare therefore sees exactly one update of both design and model, whether the cause is a buffered compare load at TOP, a turn in the dual-slope shape or a prescaled tick.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    typedef enum logic [1:0] {
        SHAPE_FREE  = 2'd0,
        SHAPE_CLEAR = 2'd1,
        SHAPE_SLOPE = 2'd2,
        SHAPE_DUAL  = 2'd3
    } shape_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CMP_A = 2'd1;
    localparam logic [1:0] ADDR_CMP_B = 2'd2;
    localparam logic [1:0] ADDR_TOP   = 2'd3;

    localparam logic [1:0] OUT_OFF    = 2'b00;
    localparam logic [1:0] OUT_TOGGLE = 2'b01;
    localparam logic [1:0] OUT_CLEAR  = 2'b10;
    localparam logic [1:0] OUT_SET    = 2'b11;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
    parameter int LOG_MID = 3,
    parameter int LOG_HI  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [LOG_HI-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + 1'b1;
        case (sel)
            2'd0:    tick = 1'b0;
            2'd1:    tick = 1'b1;
            2'd2:    tick = &pre_q[LOG_MID-1:0];
            default: tick = &pre_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  shape_t           shape,
    input  logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] cnt,
    output logic             load,
    output logic             ovf,
    output logic             cap
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             down;
        logic             ovf;
        logic             cap;
    } cstate_t;

    cstate_t s_d, s_q;
    logic at_top, at_max, at_bot, pwm;

    always_comb begin
        at_top = (s_q.cnt == top);
        at_max = &s_q.cnt;
        at_bot = (s_q.cnt == '0);
        pwm    = (shape == SHAPE_SLOPE) || (shape == SHAPE_DUAL);
        s_d     = s_q;
        s_d.ovf = 1'b0;
        s_d.cap = 1'b0;
        if (tick) begin
            case (shape)
                SHAPE_FREE: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.ovf = at_max;
                end
                SHAPE_CLEAR: begin
                    s_d.cnt = at_top ? '0 : s_q.cnt + 1'b1;
                    s_d.ovf = at_max;
                    s_d.cap = at_top;
                end
                SHAPE_SLOPE: begin
                    s_d.cnt = at_top ? '0 : s_q.cnt + 1'b1;
                    s_d.ovf = at_top;
                    s_d.cap = at_top;
                end
                default: begin
                    s_d.cap = at_top;
                    s_d.ovf = s_q.down && at_bot;
                    if (top == '0) begin
                        s_d.cnt  = '0;
                        s_d.down = 1'b0;
                    end else if (!s_q.down) begin
                        if (s_q.cnt >= top) begin
                            s_d.down = 1'b1;
                            s_d.cnt  = s_q.cnt - 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else if (at_bot) begin
                        s_d.down = 1'b0;
                        s_d.cnt  = {{(WIDTH-1){1'b0}}, 1'b1};
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
            endcase
        end
        if (shape != SHAPE_DUAL) s_d.down = 1'b0;
        load = tick && pwm && at_top;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign ovf = s_q.ovf;
    assign cap = s_q.cap;

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt));
    assert_clear_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && shape == SHAPE_CLEAR && s_q.cnt == top) |=> (s_q.cnt == '0));
    assert_slope_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && shape == SHAPE_SLOPE && s_q.cnt == top) |=> (s_q.ovf && s_q.cap));
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
    import cmp_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [WIDTH-1:0] cnt,
    input  logic             pwm,
    input  logic             load,
    input  logic             wr_cmp,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       mode,
    input  logic             dir_en,
    output logic             level,
    output logic             override,
    output logic             drive
);
    typedef struct packed {
        logic [WIDTH-1:0] buffer;
        logic [WIDTH-1:0] live;
        logic             pin;
    } chstate_t;

    chstate_t c_d, c_q;
    logic match;

    always_comb begin
        match = tick && (cnt == c_q.live);
        c_d   = c_q;
        if (wr_cmp) begin
            c_d.buffer = wr_data;
            if (!pwm) c_d.live = wr_data;
        end
        if (load) c_d.live = c_q.buffer;
        if (match) begin
            case (mode)
                OUT_TOGGLE: c_d.pin = ~c_q.pin;
                OUT_CLEAR:  c_d.pin = 1'b0;
                OUT_SET:    c_d.pin = 1'b1;
                default:    c_d.pin = c_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign level    = c_q.pin;
    assign override = (mode != OUT_OFF);
    assign drive    = override && dir_en;

    assert_clear_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OUT_CLEAR) |=> !c_q.pin);
    assert_set_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OUT_SET) |=> c_q.pin);
    assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_OFF) |=> $stable(c_q.pin));
    assert_buffer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !load) |=> $stable(c_q.live));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int LOG_MID = 3,
    parameter int LOG_HI  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       clk_sel,
    input  logic [1:0]       dir_en,
    output logic [1:0]       oc_level,
    output logic [1:0]       oc_override,
    output logic [1:0]       oc_drive,
    output logic [WIDTH-1:0] cnt_o,
    output logic             ovf_flag,
    output logic             cap_flag
);
    localparam int NCH = 2;

    typedef struct packed {
        shape_t           shape;
        logic [1:0]       mode_a;
        logic [1:0]       mode_b;
        logic [WIDTH-1:0] top;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic tick, load, pwm;
    logic [1:0] mode_arr [NCH];
    logic [NCH-1:0] wr_cmp;

    always_comb begin
        r_d = r_q;
        if (wr_en && wr_addr == ADDR_CTRL) begin
            r_d.shape  = shape_t'(wr_data[1:0]);
            r_d.mode_a = wr_data[3:2];
            r_d.mode_b = wr_data[5:4];
        end
        if (wr_en && wr_addr == ADDR_TOP) r_d.top = wr_data;
        wr_cmp[0] = wr_en && (wr_addr == ADDR_CMP_A);
        wr_cmp[1] = wr_en && (wr_addr == ADDR_CMP_B);
        pwm = (r_q.shape == SHAPE_SLOPE) || (r_q.shape == SHAPE_DUAL);
        mode_arr[0] = r_q.mode_a;
        mode_arr[1] = r_q.mode_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    cmp_timer_prescale #(.LOG_MID(LOG_MID), .LOG_HI(LOG_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
    );

    cmp_timer_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .shape(r_q.shape), .top(r_q.top),
        .cnt(cnt_o), .load(load), .ovf(ovf_flag), .cap(cap_flag)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmp_timer_channel #(.WIDTH(WIDTH)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_o), .pwm(pwm),
            .load(load), .wr_cmp(wr_cmp[i]), .wr_data(wr_data),
            .mode(mode_arr[i]), .dir_en(dir_en[i]),
            .level(oc_level[i]), .override(oc_override[i]), .drive(oc_drive[i])
        );
    end
endmodule

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
    localparam int W     = 8;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0] clk_sel = '0;
    logic [1:0] dir_en = '0;
    logic [1:0] oc_level, oc_override, oc_drive;
    logic [W-1:0] cnt_o;
    logic ovf_flag, cap_flag;

    always #(CLK_P/2) clk = ~clk;

    cmp_timer #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_sel(clk_sel), .dir_en(dir_en), .oc_level(oc_level),
        .oc_override(oc_override), .oc_drive(oc_drive), .cnt_o(cnt_o),
        .ovf_flag(ovf_flag), .cap_flag(cap_flag)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    string lvl_tag = "";

    // bench model, written from the requirements
    logic [5:0]   m_pre;
    logic [W-1:0] m_cnt, m_top;
    logic         m_down, m_ovf, m_cap;
    logic [1:0]   m_shape;
    logic [1:0]   m_mode [2];
    logic [W-1:0] m_buf [2];
    logic [W-1:0] m_live [2];
    logic         m_pin [2];
    logic         t_tick, t_load;
    logic [1:0]   t_match;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_top = 0; m_down = 0; m_ovf = 0; m_cap = 0;
            m_shape = 0;
            for (int c = 0; c < 2; c++) begin
                m_mode[c] = 0; m_buf[c] = 0; m_live[c] = 0; m_pin[c] = 0;
            end
        end else begin
            t_tick = (clk_sel == 2'd1) || (clk_sel == 2'd2 && m_pre[2:0] == 3'd7) ||
                     (clk_sel == 2'd3 && m_pre == 6'd63);
            t_load = t_tick && m_shape >= 2 && m_cnt == m_top;
            for (int c = 0; c < 2; c++) t_match[c] = t_tick && m_cnt == m_live[c];
            m_pre = m_pre + 1;
            m_ovf = 0; m_cap = 0;
            for (int c = 0; c < 2; c++) begin
                if (t_match[c]) begin
                    if (m_mode[c] == 2'b01) m_pin[c] = ~m_pin[c];
                    else if (m_mode[c] == 2'b10) m_pin[c] = 0;
                    else if (m_mode[c] == 2'b11) m_pin[c] = 1;
                end
                if (t_load) m_live[c] = m_buf[c];
                if (wr_en && wr_addr == 2'(c + 1)) begin
                    if (m_shape < 2) m_live[c] = wr_data;
                    m_buf[c] = wr_data;
                end
            end
            if (t_tick) begin
                if (m_shape == 0) begin
                    m_ovf = (m_cnt == 8'hFF); m_cnt = m_cnt + 1;
                end else if (m_shape == 1 || m_shape == 2) begin
                    m_cap = (m_cnt == m_top);
                    m_ovf = (m_shape == 1) ? (m_cnt == 8'hFF) : m_cap;
                    m_cnt = m_cap ? 8'd0 : m_cnt + 1;
                end else begin
                    m_cap = (m_cnt == m_top);
                    m_ovf = m_down && m_cnt == 0;
                    if (m_top == 0) begin
                        m_cnt = 0; m_down = 0;
                    end else if (!m_down) begin
                        if (m_cnt >= m_top) begin m_down = 1; m_cnt = m_cnt - 1; end
                        else m_cnt = m_cnt + 1;
                    end else if (m_cnt == 0) begin
                        m_down = 0; m_cnt = 1;
                    end else m_cnt = m_cnt - 1;
                end
            end
            if (m_shape != 3) m_down = 0;
            if (wr_en && wr_addr == 2'd0) begin
                m_shape = wr_data[1:0]; m_mode[0] = wr_data[3:2]; m_mode[1] = wr_data[5:4];
            end
            if (wr_en && wr_addr == 2'd3) m_top = wr_data;
        end
    end

    function automatic string shape_tag();
        if (clk_sel == 2'd0 || clk_sel == 2'd3) return "R2";
        case (m_shape)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic string level_tag(input int c);
        if (lvl_tag != "") return lvl_tag;
        if (c == 1) return "R13";
        if (m_shape >= 2) return "R11";
        if (m_mode[0] == 2'b00) return "R9";
        if (m_mode[0] == 2'b01) return "R7";
        return "R8";
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp,
                       inout bit ok);
        if (act != exp) begin
            ok = 1'b0;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #(CLK_P/4);
        cycles++;
        if (chk_on) begin
            bit ok = 1'b1;
            cmp(shape_tag(), "cnt", int'(cnt_o), int'(m_cnt), ok);
            cmp(shape_tag(), "ovf", int'(ovf_flag), int'(m_ovf), ok);
            cmp(shape_tag(), "cap", int'(cap_flag), int'(m_cap), ok);
            for (int c = 0; c < 2; c++) begin
                cmp(level_tag(c), "level", int'(oc_level[c]), int'(m_pin[c]), ok);
                cmp("R10", "override", int'(oc_override[c]), int'(m_mode[c] != 0), ok);
                cmp("R10", "drive", int'(oc_drive[c]), int'(m_mode[c] != 0 && dir_en[c]), ok);
            end
            n_vec++;
            if (!ok) n_bad++;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #(CLK_P/4);
        begin
            bit ok = 1'b1;
            cmp("R1", "cnt", int'(cnt_o), 0, ok);
            cmp("R1", "level", int'(oc_level), 0, ok);
            cmp("R1", "override", int'(oc_override), 0, ok);
            cmp("R1", "drive", int'(oc_drive), 0, ok);
            cmp("R1", "flags", int'({ovf_flag, cap_flag}), 0, ok);
            n_vec++;
            if (!ok) n_bad++;
        end
        chk_on = 1'b1;

        for (int w = 0; w < 4; w++) begin
            for (int ca = 0; ca < 4; ca++) begin
                for (int s = 1; s < 3; s++) begin
                    clk_sel = 2'(s);
                    dir_en  = 2'(ca);
                    reg_wr(2'd0, {2'b00, 2'(3 - ca), 2'(ca), 2'(w)});
                    reg_wr(2'd3, W'(7 + ca));
                    reg_wr(2'd1, W'(3));
                    reg_wr(2'd2, W'(5));
                    idle(120);
                    reg_wr(2'd1, W'(6));
                    idle(120);
                    reg_wr(2'd2, W'(1));
                    idle(60);
                end
            end
        end

        // prescale extremes: divide by 64, then stopped
        reg_wr(2'd0, {2'b00, 2'b01, 2'b01, 2'b10});
        reg_wr(2'd3, W'(4));
        clk_sel = 2'd3;
        idle(1500);
        clk_sel = 2'd0;
        idle(200);

        // immediate compare update in the clearing shape
        lvl_tag = "R12";
        clk_sel = 2'd1;
        reg_wr(2'd0, {2'b00, 2'b00, 2'b01, 2'b01});
        reg_wr(2'd3, W'(40));
        for (int v = 2; v < 38; v += 5) begin
            reg_wr(2'd1, W'(v));
            idle(17);
        end

        // dual slope with TOP of 0, then a TOP below the count
        lvl_tag = "";
        reg_wr(2'd0, {2'b00, 2'b11, 2'b10, 2'b11});
        reg_wr(2'd3, W'(0));
        idle(30);
        reg_wr(2'd3, W'(50));
        idle(60);
        reg_wr(2'd3, W'(10));
        idle(80);
        finish_run();
    end
endmodule